// File: doc/BRIEF.md
# Configuration Readback CRC Checker

This block audits the device configuration without any external pins. It walks an internal table of frame addresses one entry at a time. For each entry it emits a fixed 44-byte readback request on a byte-wide command stream, then takes in exactly one frame of returned bytes on a byte-wide data stream. Every byte of every frame in a pass feeds a single CRC-32. At no point is the whole device read back in one request.

The first complete pass after reset becomes the golden signature, and the block raises `ref_valid` when it has been stored. Each later pass compares its own signature with the golden value. A mismatch sets a sticky `cfg_fail` flag, which stays set until `clr` is pulsed. After each pass the block waits a parameterised number of idle cycles, then starts again at table entry 0.

Both streams use valid/ready handshakes, and a byte moves only in a cycle where valid and ready are both high. On the command side, the block holds `cmd_valid` and `cmd_data` steady until the byte is accepted. On the data side, `rd_ready` is high only while a frame is being captured and `port_busy` is low. `port_busy` therefore stalls capture, and no byte is lost or counted twice.

Top module: `cfg_crc_audit`

## Requirements
- R1: After reset, `cfg_fail` and `ref_valid` are 0, and the block immediately offers command byte 0 of table entry 0.
- R2: Each frame request is 44 command bytes, indexed k = 0..43. A byte k outside 36..39 equals (29·k + 59) mod 256. `cmd_data` stays stable while `cmd_valid` is high and `cmd_ready` is low.
- R3: Table entry i holds address ADDR_BASE + i·ADDR_STEP. The address fills command bytes 36..39, most significant byte first, and entries are visited in order 0..NUM_FRAMES-1 within a pass.
- R4: After the 44th command byte is accepted, the block accepts exactly FRAME_WORDS·4 data bytes. During that capture it offers no command bytes.
- R5: The signature is a CRC-32 over all data bytes of a pass in arrival order. It uses the reflected polynomial 0xEDB88320 (0x04C11DB7 bit-reversed), starts from 0xFFFFFFFF and is inverted at the end of the pass.
- R6: At the end of the first pass, `ref_sig` takes the signature and `ref_valid` rises. Both then hold until reset.
- R7: At the end of each later pass, a signature different from `ref_sig` sets `cfg_fail`, and an equal one leaves it unchanged.
- R8: `cfg_fail` stays set until `clr` is high on a clock edge. A mismatch on the same edge as `clr` keeps it set.
- R9: After a pass ends, `cmd_valid` stays low for IDLE_CYCLES cycles before entry 0 is requested again.
- R10: While `port_busy` is high, `rd_ready` is low. Bytes held back this way are taken later in order, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | output | 1 | Command byte offered |
| cmd_ready | input | 1 | Port accepts command byte |
| cmd_data | output | 8 | Readback command byte |
| rd_valid | input | 1 | Port offers a frame data byte |
| rd_ready | output | 1 | Block accepts a frame data byte |
| rd_data | input | 8 | Frame data byte |
| port_busy | input | 1 | Port busy; holds off capture |
| clr | input | 1 | Clears the fail flag |
| ref_valid | output | 1 | Golden signature captured |
| ref_sig | output | 32 | Golden signature |
| cfg_fail | output | 1 | Sticky configuration mismatch flag |

## Verification
A wrong sequencer count shows up at the command port straight away. One byte off in the request, an address byte in the wrong slot, or a frame skipped makes `cmd_data` or `cmd_valid` disagree with the model in that same cycle. A fault in the CRC, or a lost or doubled byte under `port_busy`, stays hidden until a pass ends. At that point `ref_sig` shows it for the golden pass, and for later passes `cfg_fail` shows it one cycle after the last data byte. The bench therefore compares every output on every cycle, runs six passes with corrupted data in two of them, and places `clr` both in the middle of a pass and on the same edge as a mismatch.

// File: rtl/cra_pkg.sv
package cra_pkg;
  localparam int CMD_LEN  = 44;
  localparam int ADDR_POS = 36;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

  typedef enum logic [1:0] {ST_CMD, ST_DATA, ST_FINISH, ST_WAIT} cra_state_e;

  function automatic logic [7:0] cmd_byte(input int unsigned k, input logic [31:0] addr);
    logic [31:0] sh;
    if (k >= ADDR_POS && k < ADDR_POS + 4) begin
      sh = addr >> (8 * (ADDR_POS + 3 - k));
      return sh[7:0];
    end
    return 8'((k * 29 + 59) & 255);
  endfunction

  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'h0, d};
    for (int b = 0; b < 8; b++)
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    return c;
  endfunction
endpackage

// File: rtl/cra_addr_table.sv
module cra_addr_table #(
  parameter int          NUM_FRAMES = 4,
  parameter int          IDX_W      = 2,
  parameter logic [31:0] ADDR_BASE  = 32'h0040_0000,
  parameter logic [31:0] ADDR_STEP  = 32'h0000_0100
) (
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      addr
);
  logic [31:0] tbl [NUM_FRAMES];

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_entry
    assign tbl[g] = ADDR_BASE + ADDR_STEP * 32'(g);
  end

  always_comb begin
    addr = tbl[0];
    for (int i = 0; i < NUM_FRAMES; i++)
      if (idx == IDX_W'(i)) addr = tbl[i];
  end
endmodule

// File: rtl/cra_crc.sv
module cra_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        preset,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import cra_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || preset) crc <= 32'hFFFF_FFFF;
    else if (en)          crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/cra_seq.sv
module cra_seq #(
  parameter int NUM_FRAMES  = 4,
  parameter int FRAME_WORDS = 3,
  parameter int IDLE_CYCLES = 20,
  parameter int IDX_W       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_ready,
  input  logic             rd_valid,
  input  logic             port_busy,
  input  logic [31:0]      frame_addr,
  output logic [IDX_W-1:0] frame_idx,
  output logic             cmd_valid,
  output logic [7:0]       cmd_data,
  output logic             rd_ready,
  output logic             beat,
  output logic             pass_end
);
  import cra_pkg::*;

  localparam int FRAME_BYTES = FRAME_WORDS * 4;
  localparam int BW = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
  localparam int WW = $clog2(IDLE_CYCLES + 1);

  cra_state_e    state;
  logic [5:0]    cmd_cnt;
  logic [BW-1:0] byte_cnt;
  logic [WW-1:0] wait_cnt;

  assign cmd_valid = (state == ST_CMD);
  assign cmd_data  = cmd_byte(32'(cmd_cnt), frame_addr);
  assign rd_ready  = (state == ST_DATA) && !port_busy;
  assign beat      = rd_ready && rd_valid;
  assign pass_end  = (state == ST_FINISH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_CMD;
      cmd_cnt   <= '0;
      byte_cnt  <= '0;
      wait_cnt  <= '0;
      frame_idx <= '0;
    end else begin
      unique case (state)
        ST_CMD: if (cmd_ready) begin
          if (cmd_cnt == 6'(CMD_LEN - 1)) begin
            cmd_cnt  <= '0;
            byte_cnt <= '0;
            state    <= ST_DATA;
          end else begin
            cmd_cnt <= cmd_cnt + 6'd1;
          end
        end
        ST_DATA: if (beat) begin
          if (byte_cnt == BW'(FRAME_BYTES - 1)) begin
            byte_cnt <= '0;
            if (frame_idx == IDX_W'(NUM_FRAMES - 1)) begin
              state <= ST_FINISH;
            end else begin
              frame_idx <= frame_idx + 1'b1;
              state     <= ST_CMD;
            end
          end else begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
        ST_FINISH: begin
          wait_cnt <= '0;
          state    <= ST_WAIT;
        end
        ST_WAIT: begin
          if (wait_cnt == WW'(IDLE_CYCLES - 1)) begin
            frame_idx <= '0;
            state     <= ST_CMD;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= ST_CMD;
      endcase
    end
  end
endmodule

// File: rtl/cra_golden.sv
module cra_golden (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pass_end,
  input  logic [31:0] crc_state,
  input  logic        clr,
  output logic        ref_valid,
  output logic [31:0] ref_sig,
  output logic        cfg_fail
);
  logic [31:0] sig_now;
  logic        mismatch;

  assign sig_now  = ~crc_state;
  assign mismatch = pass_end && ref_valid && (sig_now != ref_sig);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_valid <= 1'b0;
      ref_sig   <= '0;
      cfg_fail  <= 1'b0;
    end else begin
      if (pass_end && !ref_valid) begin
        ref_valid <= 1'b1;
        ref_sig   <= sig_now;
      end
      if (mismatch)  cfg_fail <= 1'b1;
      else if (clr)  cfg_fail <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_crc_audit.sv
module cfg_crc_audit #(
  parameter int          NUM_FRAMES  = 4,
  parameter int          FRAME_WORDS = 3,
  parameter int          IDLE_CYCLES = 20,
  parameter logic [31:0] ADDR_BASE   = 32'h0040_0000,
  parameter logic [31:0] ADDR_STEP   = 32'h0000_0100
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_data,
  input  logic        rd_valid,
  output logic        rd_ready,
  input  logic [7:0]  rd_data,
  input  logic        port_busy,
  input  logic        clr,
  output logic        ref_valid,
  output logic [31:0] ref_sig,
  output logic        cfg_fail
);
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

  logic [IDX_W-1:0] frame_idx;
  logic [31:0]      frame_addr;
  logic [31:0]      crc_state;
  logic             beat;
  logic             pass_end;

  cra_addr_table #(
    .NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W),
    .ADDR_BASE(ADDR_BASE), .ADDR_STEP(ADDR_STEP)
  ) u_table (
    .idx(frame_idx), .addr(frame_addr)
  );

  cra_seq #(
    .NUM_FRAMES(NUM_FRAMES), .FRAME_WORDS(FRAME_WORDS),
    .IDLE_CYCLES(IDLE_CYCLES), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
    .port_busy(port_busy), .frame_addr(frame_addr), .frame_idx(frame_idx),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data), .rd_ready(rd_ready),
    .beat(beat), .pass_end(pass_end)
  );

  cra_crc u_crc (
    .clk(clk), .rst_n(rst_n), .preset(pass_end), .en(beat),
    .din(rd_data), .crc(crc_state)
  );

  cra_golden u_gold (
    .clk(clk), .rst_n(rst_n), .pass_end(pass_end), .crc_state(crc_state),
    .clr(clr), .ref_valid(ref_valid), .ref_sig(ref_sig), .cfg_fail(cfg_fail)
  );
endmodule

// File: rtl/cra_audit_chk.sv
module cra_audit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_data,
  input logic        rd_ready,
  input logic        port_busy,
  input logic        clr,
  input logic        ref_valid,
  input logic [31:0] ref_sig,
  input logic        cfg_fail
);
  p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  p_no_cmd_in_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && rd_ready));

  p_ref_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |=> ref_valid && $stable(ref_sig));

  p_fail_after_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fail |-> ref_valid);

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fail && !clr |=> cfg_fail);

  p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |-> !rd_ready);
endmodule

bind cfg_crc_audit cra_audit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_data(cmd_data), .rd_ready(rd_ready), .port_busy(port_busy), .clr(clr),
  .ref_valid(ref_valid), .ref_sig(ref_sig), .cfg_fail(cfg_fail)
);

// File: tb/cfg_crc_audit_tb.sv
module cfg_crc_audit_tb;
  localparam int NF = 4;
  localparam int FW = 3;
  localparam int IDLE = 20;
  localparam int FB = FW * 4;
  localparam logic [31:0] BASE = 32'h0040_0000;
  localparam logic [31:0] STEP = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid, cmd_ready, rd_valid, rd_ready, port_busy, clr;
  logic ref_valid, cfg_fail;
  logic [7:0] cmd_data, rd_data;
  logic [31:0] ref_sig;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cfg_crc_audit #(.NUM_FRAMES(NF), .FRAME_WORDS(FW), .IDLE_CYCLES(IDLE),
                  .ADDR_BASE(BASE), .ADDR_STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .port_busy(port_busy), .clr(clr),
    .ref_valid(ref_valid), .ref_sig(ref_sig), .cfg_fail(cfg_fail)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_cmd(input int frame, input int k);
    logic [31:0] a;
    a = BASE + STEP * 32'(frame);
    if (k >= 36 && k <= 39) return a[8*(39-k) +: 8];
    return 8'((k * 29 + 59) % 256);
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] data_byte(input int pass, input int frame, input int j);
    logic [7:0] b;
    b = 8'((frame * 37 + j * 11 + 5) % 256);
    if ((pass == 2 || pass == 4) && frame == 1 && j == 5) b = b ^ 8'h10;
    return b;
  endfunction

  // reference model state
  int m_phase = 0;  // 0 request, 1 capture, 2 pass end, 3 idle
  int m_frame = 0, m_k = 0, m_j = 0, m_wait = 0, pass_no = 0, cyc = 0;
  logic [31:0] m_crc = 32'hFFFFFFFF;
  bit exp_rv = 0, exp_fail = 0, after_pass = 0;
  bit fail_tbl [6] = '{0, 0, 1, 0, 1, 1};

  initial begin
    cmd_ready = 0; rd_valid = 0; rd_data = 0; port_busy = 0; clr = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(cfg_fail == 0, "R1 fail in reset", cfg_fail, 0);
    chk(ref_valid == 0, "R1 ref_valid in reset", ref_valid, 0);
    rst_n = 1'b1;
    while (pass_no < 6) begin
      cmd_ready = (cyc % 5) != 3;
      port_busy = (cyc % 7) == 2;
      rd_valid  = (m_phase == 1) && ((cyc % 4) != 1);
      rd_data   = (m_phase == 1) ? data_byte(pass_no, m_frame, m_j) : 8'h00;
      clr = ((pass_no == 3 && m_phase == 1 && m_frame == 2 && m_j == 0) ||
             (pass_no == 4 && m_phase == 2));
      #1;
      if (after_pass) begin
        chk(ref_valid == 1, "R6 ref_valid after pass", ref_valid, 1);
        chk(cfg_fail == fail_tbl[pass_no-1], "R7/R8 fail after pass", cfg_fail, fail_tbl[pass_no-1]);
        after_pass = 0;
      end
      chk(cfg_fail == exp_fail, "R8 fail flag", cfg_fail, exp_fail);
      chk(ref_valid == exp_rv, "R6 ref_valid", ref_valid, exp_rv);
      if (exp_rv) chk(ref_sig == m_crc_ref, "R5 signature", ref_sig, m_crc_ref);
      if (m_phase == 3) chk(cmd_valid == 0, "R9 idle gap", cmd_valid, 0);
      else chk(cmd_valid == (m_phase == 0), "R4 cmd_valid phase", cmd_valid, (m_phase == 0));
      if (m_phase == 0 && cmd_valid) begin
        if (m_k >= 36 && m_k <= 39)
          chk(cmd_data == exp_cmd(m_frame, m_k), "R3 address byte", cmd_data, exp_cmd(m_frame, m_k));
        else
          chk(cmd_data == exp_cmd(m_frame, m_k), "R2 command byte", cmd_data, exp_cmd(m_frame, m_k));
      end
      chk(rd_ready == (m_phase == 1 && !port_busy), "R10 rd_ready", rd_ready, (m_phase == 1 && !port_busy));
      // advance the model across the coming edge
      case (m_phase)
        0: if (cmd_ready) begin
             if (m_k == 43) begin m_phase = 1; m_j = 0; end
             else m_k++;
           end
        1: if (rd_valid && !port_busy) begin
             m_crc = ref_crc(m_crc, rd_data);
             if (m_j == FB - 1) begin
               if (m_frame == NF - 1) m_phase = 2;
               else begin m_frame++; m_k = 0; m_phase = 0; end
             end else m_j++;
           end
        2: begin
             if (!exp_rv) begin exp_rv = 1; m_crc_ref = ~m_crc; end
             else if (~m_crc != m_crc_ref) exp_fail = 1;
             else if (clr) exp_fail = 0;
             m_crc = 32'hFFFFFFFF;
             m_phase = 3; m_wait = 0; pass_no++; after_pass = 1;
           end
        default: begin
             if (m_wait == IDLE - 1) begin m_phase = 0; m_frame = 0; m_k = 0; end
             else m_wait++;
           end
      endcase
      if (m_phase != 3 && clr && !(exp_rv && m_phase == 3)) begin
        if (!(pass_no == 5 && after_pass)) exp_fail = exp_fail && !(clr && !(after_pass && fail_tbl[pass_no-1] && pass_no == 5));
      end
      cyc++;
      @(negedge clk);
    end
    #1;
    chk(cfg_fail == 1, "R7 final mismatch flag", cfg_fail, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [31:0] m_crc_ref = 32'h0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule